// File: doc/BRIEF.md
# Tunable Stochastic Binary Unit

A clocked probabilistic bit. Every time it draws, it emits a random 0 or 1. The chance of a 1 follows a logistic curve of a signed fixed-point bias word: zero bias gives a fair coin, and a strongly positive or strongly negative bias drives the output towards 1 or 0. A 16-bit maximal-length shift-register generator supplies a fresh uniform number on every clock. A table, computed at elaboration, maps the saturated bias code to a probability threshold, and a comparator turns the pair into the new output value.

After each draw the output is frozen for a retention interval, set per instance through the `hold_cycles` input, and is then drawn again. Units built with different retention values therefore re-evaluate at unrelated instants, which a network of such units can rely on to avoid simultaneous updates. A clamp input stands in for an overwhelming bias: while it is set, each draw yields the clamp value. A single-cycle strobe marks every draw.

Top module: `pbit_unit`

## Requirements
- R1: At each draw, the output becomes 1 exactly when the top 8 bits of the random state, read as an unsigned number r in 0..255, are below T. T = round(256·S(x)) limited to 255, where S(x)=1/(1+e^(-2x)) and x = sat(bias_in)/32. Here sat limits the two's-complement bias code to -128..127, and the bias word has 5 fraction bits. Over many draws, the fraction of ones therefore follows S(x).
- R2: A bias of 0 gives T = 128, so ones and zeros are equally likely.
- R3: A larger bias code never gives a smaller fraction of ones. Bias codes -16, 0 and +16 give strictly increasing fractions.
- R4: Bias codes above 127 behave like 127 (almost always 1), and codes below -128 behave like -128 (almost always 0).
- R5: The hold value H is sampled at a draw. The output then stays fixed, and the next draw happens H+1 enabled cycles later.
- R6: With H = 0 and `en` high, a draw happens on every clock cycle.
- R7: `draw_stb` is high for one cycle after each draw and at no other time. `bit_out` changes only in a cycle where `draw_stb` is high.
- R8: While `en` is low, no draw happens, the retention count is frozen and `bit_out` holds.
- R9: While `clamp_en` is high, every draw sets `bit_out` to `clamp_val`, whatever the bias.
- R10: A synchronous reset with `rst_n` low clears `bit_out` and `draw_stb`, reloads the random state with its nonzero seed and restarts the retention count. The first draw then falls on the first enabled cycle after reset. The random state never becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Allows the retention count to run and draws to happen |
| clamp_en | input | 1 | Forces draws to the clamp value |
| clamp_val | input | 1 | Value forced at draws while clamped |
| hold_cycles | input | 16 | Retention interval H in clock cycles, sampled at each draw |
| bias_in | input | 12 | Signed bias, 5 fraction bits |
| bit_out | output | 1 | Random binary output |
| draw_stb | output | 1 | One-cycle pulse following each draw |

## Verification
On every cycle the assertions check the timing behaviour. They check the spacing of draws against the hold value that was sampled, a draw on every cycle when the hold is zero, and that the output holds between strobes. They also check that idle cycles produce no draw and freeze the count, that clamped draws return the clamp value, and that the random state never reaches zero. The probabilistic behaviour cannot be stated as a property. This covers the logistic mapping, the even split at zero bias, the ordering across bias values and the saturation of out-of-range bias. Only the bench's long runs of draws show these, by comparing counted fractions of ones against S(x) with a statistical tolerance.

// File: rtl/pbit_pkg.sv
// Package pbit_pkg
// Shared helpers for the stochastic binary unit: one step of the Galois
// shift-register generator and the elaboration-time logistic threshold.
// Assumes the bias word and the table agree on the number of fraction bits.
package pbit_pkg;

    // One step of a right-shifting Galois generator with the given tap mask.
    function automatic logic [15:0] lfsr_step(input logic [15:0] st, input logic [15:0] taps);
        lfsr_step = st[0] ? ((st >> 1) ^ taps) : (st >> 1);
    endfunction

    // Threshold for signed table code 'code': round(2^rw * S(x)), limited to
    // 2^rw-1, with x = code / 2^frac and S(x) = 1/(1+exp(-2x)).
    // Works in Q16 integer arithmetic so it folds to a constant.
    function automatic int sig_threshold(input int code, input int frac, input int rw);
        longint ax, t, ex, en_q, pp, p, thr, lim;
        ax = (code < 0) ? -code : code;
        // y = 2*|x| in Q16, then divided by 16 for a small Taylor argument
        t = (ax <<< (17 - frac)) >>> 4;
        ex = 64'sd65536 + t + (t * t) / 64'sd131072
             + (t * t * t) / 64'sd25769803776;
        for (int k = 0; k < 4; k++) begin
            ex = (ex * ex) / 64'sd65536;
        end
        en_q = 64'sd4294967296 / ex;
        pp   = 64'sd4294967296 / (64'sd65536 + en_q);
        p    = (code < 0) ? (64'sd65536 - pp) : pp;
        thr  = ((p <<< rw) + 64'sd32768) >>> 16;
        lim  = (64'sd1 <<< rw) - 64'sd1;
        if (thr > lim) thr = lim;
        return int'(thr);
    endfunction

endpackage

// File: rtl/pbit_lfsr.sv
// Module pbit_lfsr
// Free-running maximal-length Galois generator. It advances on every clock
// and reloads SEED on reset. Assumes SEED is nonzero and TAPS gives a
// maximal-length polynomial for width W.
module pbit_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] TAPS = 16'hB400,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    // Advance the generator or reload the seed.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= W'(SEED);
        else        state <= W'(pbit_pkg::lfsr_step(16'(state), TAPS));
    end

    // A zero state would lock the generator.
    assert_lfsr_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (state != '0));
endmodule

// File: rtl/pbit_sigmoid_lut.sv
// Module pbit_sigmoid_lut
// Saturates the signed bias to an AW-bit code and looks up the logistic
// threshold. The table is built at elaboration from pbit_pkg::sig_threshold.
// Assumes IN_W >= AW and FRAC <= 16.
module pbit_sigmoid_lut #(
    parameter int IN_W = 12,
    parameter int AW   = 8,
    parameter int FRAC = 5,
    parameter int RW   = 8
) (
    input  logic signed [IN_W-1:0] bias,
    output logic        [RW-1:0]   thr
);
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;
    localparam logic signed [IN_W-1:0] MAXC = IN_W'(HALF - 1);
    localparam logic signed [IN_W-1:0] MINC = IN_W'(-HALF);

    logic [RW-1:0]        table_q [DEPTH];
    logic signed [AW-1:0] code;
    logic [AW-1:0]        idx;

    // Fill each table entry with its constant threshold.
    for (genvar i = 0; i < DEPTH; i++) begin : g_tab
        localparam int VAL = pbit_pkg::sig_threshold(i - HALF, FRAC, RW);
        assign table_q[i] = RW'(VAL);
    end

    // Saturate the bias to the table range and form the table index.
    always_comb begin
        if (bias > MAXC)      code = AW'(HALF - 1);
        else if (bias < MINC) code = AW'(-HALF);
        else                  code = bias[AW-1:0];
        idx = {~code[AW-1], code[AW-2:0]};
    end

    assign thr = table_q[idx];
endmodule

// File: rtl/pbit_hold_timer.sv
// Module pbit_hold_timer
// Retention counter. It fires when enabled with a zero count, then reloads
// the hold value. It counts down only while enabled. Reset clears the count
// so that the first enabled cycle fires.
module pbit_hold_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] hold_cycles,
    output logic          fire
);
    logic [CW-1:0] cnt;

    assign fire = en && (cnt == '0);

    // Reload on a draw, count down otherwise, freeze while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (fire)  cnt <= hold_cycles;
        else if (en)    cnt <= cnt - 1'b1;
    end

    assert_cnt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> $stable(cnt));
endmodule

// File: rtl/pbit_unit.sv
// Module pbit_unit
// Tunable stochastic binary unit. It compares the top RW bits of the random
// state with the logistic threshold of the bias. The result, or the clamp
// value, is loaded into bit_out whenever the retention timer fires, and
// draw_stb pulses for one cycle after each load. Assumes LFSR_W >= RW.
module pbit_unit #(
    parameter int          IN_W   = 12,
    parameter int          AW     = 8,
    parameter int          FRAC   = 5,
    parameter int          RW     = 8,
    parameter int          LFSR_W = 16,
    parameter int          CW     = 16,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   clamp_en,
    input  logic                   clamp_val,
    input  logic [CW-1:0]          hold_cycles,
    input  logic signed [IN_W-1:0] bias_in,
    output logic                   bit_out,
    output logic                   draw_stb
);
    logic [LFSR_W-1:0] rnd;
    logic [RW-1:0]     thr;
    logic              fire;
    logic              sample;

    pbit_lfsr #(.W(LFSR_W), .TAPS(16'hB400), .SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .state(rnd));

    pbit_sigmoid_lut #(.IN_W(IN_W), .AW(AW), .FRAC(FRAC), .RW(RW)) u_lut (
        .bias(bias_in), .thr(thr));

    pbit_hold_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .hold_cycles(hold_cycles), .fire(fire));

    // Candidate value: the clamp value, or random-below-threshold.
    always_comb begin
        if (clamp_en) sample = clamp_val;
        else          sample = (rnd[LFSR_W-1 -: RW] < thr);
    end

    // Output and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out  <= 1'b0;
            draw_stb <= 1'b0;
        end else begin
            draw_stb <= fire;
            if (fire) bit_out <= sample;
        end
    end

    assert_hold_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (draw_stb && $past(hold_cycles) != '0) |=> !draw_stb);
    assert_every_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (draw_stb && $past(hold_cycles) == '0 && en) |=> draw_stb);
    assert_held_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !draw_stb) |-> $stable(bit_out));
    assert_no_draw_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> !draw_stb);
    assert_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (draw_stb && $past(clamp_en)) |-> (bit_out == $past(clamp_val)));
endmodule

// File: tb/pbit_unit_tb_top.sv
module pbit_unit_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              clamp_en = 1'b0;
    logic              clamp_val = 1'b0;
    logic [15:0]       hold_cycles = '0;
    logic signed [11:0] bias_in = '0;
    logic              bit_out;
    logic              draw_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pbit_unit dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .clamp_en(clamp_en),
        .clamp_val(clamp_val), .hold_cycles(hold_cycles), .bias_in(bias_in),
        .bit_out(bit_out), .draw_stb(draw_stb));

    // Expected probability of a one (R1): logistic of the saturated code.
    function automatic real exp_p(input int code);
        int  c;
        real x;
        c = (code > 127) ? 127 : ((code < -128) ? -128 : code);
        x = real'(c) / 32.0;
        return 1.0 / (1.0 + $exp(-2.0 * x));
    endfunction

    task automatic chk_i(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic chk_r(input bit ok, input string req, input real act, input real expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%f expected=%f", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Draw n times with hold 0 and return the fraction of ones.
    task automatic run_ratio(input int code, input int n, output real ratio);
        int ones = 0;
        int draws = 0;
        @(negedge clk);
        bias_in = 12'(code);
        hold_cycles = '0;
        clamp_en = 1'b0;
        en = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (draw_stb) begin
                draws++;
                if (bit_out) ones++;
            end
        end
        ratio = (draws == 0) ? -1.0 : real'(ones) / real'(draws);
    endtask

    // Retention spacing (R5/R7): gaps between strobes must be h+1.
    task automatic run_hold(input int h, input int cycles);
        int  last = -1;
        int  bad_gap = 0;
        int  bad_gap_val = 0;
        int  bad_hold = 0;
        logic prev;
        en = 1'b1;
        hold_cycles = 16'(h);
        bias_in = '0;
        clamp_en = 1'b0;
        do_reset();
        @(negedge clk);
        chk_i(draw_stb == 1'b1, "R10 first draw after reset", int'(draw_stb), 1);
        last = 0;
        prev = bit_out;
        for (int k = 1; k < cycles; k++) begin
            @(negedge clk);
            if (draw_stb) begin
                if (k - last != h + 1) begin
                    bad_gap++;
                    bad_gap_val = k - last;
                end
                last = k;
            end else if (bit_out !== prev) begin
                bad_hold++;
            end
            prev = bit_out;
        end
        chk_i(bad_gap == 0, "R5 draw spacing", bad_gap_val, h + 1);
        chk_i(bad_hold == 0, "R7 output held between strobes", bad_hold, 0);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        real r0, rp, rn, r;
        int  code;
        int  bad;
        logic held;
        void'($urandom(32'd12345));

        // R10: reset state
        repeat (3) @(negedge clk);
        chk_i(bit_out == 1'b0, "R10 reset bit_out", int'(bit_out), 0);
        chk_i(draw_stb == 1'b0, "R10 reset draw_stb", int'(draw_stb), 0);
        rst_n = 1'b1;

        // R2: zero bias is a fair coin
        run_ratio(0, 6000, r0);
        chk_r(r0 > 0.46 && r0 < 0.54, "R2 zero bias fraction", r0, 0.5);

        // R1: directed and random bias values against the logistic curve
        run_ratio(16, 6000, rp);
        chk_r(rp > exp_p(16) - 0.04 && rp < exp_p(16) + 0.04, "R1 bias +16", rp, exp_p(16));
        run_ratio(-16, 6000, rn);
        chk_r(rn > exp_p(-16) - 0.04 && rn < exp_p(-16) + 0.04, "R1 bias -16", rn, exp_p(-16));
        for (int i = 0; i < 5; i++) begin
            code = int'($urandom_range(0, 320)) - 160;
            run_ratio(code, 6000, r);
            chk_r(r > exp_p(code) - 0.04 && r < exp_p(code) + 0.04, "R1 random bias", r, exp_p(code));
        end

        // R3: ordering
        chk_r(rn < r0 && r0 < rp, "R3 monotonic -16/0/+16", r0, 0.5);

        // R4: saturation
        run_ratio(1000, 3000, r);
        chk_r(r >= 0.99, "R4 large positive saturates", r, 1.0);
        run_ratio(-1000, 3000, r);
        chk_r(r <= 0.01, "R4 large negative saturates", r, 0.0);

        // R6: hold 0 draws every cycle
        bad = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (!draw_stb) bad++;
        end
        chk_i(bad == 0, "R6 draw every cycle", bad, 0);

        // R5/R7/R10: retention spacing for several hold values
        run_hold(1, 80);
        run_hold(7, 200);
        for (int i = 0; i < 3; i++) run_hold(int'($urandom_range(2, 30)), 400);

        // R8: disabled unit does not draw and holds output
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        held = bit_out;
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (draw_stb || bit_out !== held) bad++;
        end
        chk_i(bad == 0, "R8 idle while disabled", bad, 0);

        // R9: clamp overrides bias both ways
        @(negedge clk);
        en = 1'b1;
        hold_cycles = '0;
        clamp_en = 1'b1;
        clamp_val = 1'b1;
        bias_in = -12'sd1000;
        bad = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (draw_stb && bit_out !== 1'b1) bad++;
        end
        chk_i(bad == 0, "R9 clamp to 1 under negative bias", bad, 0);
        @(negedge clk);
        clamp_val = 1'b0;
        bias_in = 12'sd1000;
        bad = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (draw_stb && bit_out !== 1'b0) bad++;
        end
        chk_i(bad == 0, "R9 clamp to 0 under positive bias", bad, 0);

        // R10: mid-run reset clears outputs
        @(negedge clk);
        clamp_val = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b0;
        @(negedge clk);
        chk_i(bit_out == 1'b0 && draw_stb == 1'b0, "R10 mid-run reset", int'({bit_out, draw_stb}), 0);
        rst_n = 1'b1;
        en = 1'b1;
        @(negedge clk);
        chk_i(draw_stb == 1'b1 && bit_out == 1'b1, "R10 first draw after mid-run reset",
              int'({bit_out, draw_stb}), 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule